// File: doc/BRIEF.md
# Three-Tier Clock Reference Selector

This block chooses which of three clock-plus-sync input groups feeds the downstream PLL: the master group, the slave group or the stand-by group. An external clock monitor supplies one alarm flag per group. The selector falls back from master to slave, then to stand-by, and finally to no source at all. It also tracks the PLL operating mode (free-run, locked, holdover). On every change of selection it raises a one-cycle flag, which a phase build-out stage uses to keep the output phase continuous across the switch.

A hardware pin pair can force the choice between master and slave. A configuration input selects revertive or non-revertive behaviour. In revertive operation, a recovered master is taken back only after its alarm has stayed clear for `HOLD_CYC` consecutive cycles. The stand-by tier can be removed at elaboration time with the `STANDBY_EN` parameter. All outputs are registered, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `refsel_top`

## Requirements
- R1: While `rst_n` is low and after it is released, until the first clock edge, `sel_o` is 3 (none), `mode_o` is 0 (free-run) and `switch_o` is 0.
- R2: In revertive operation without a forced choice, the selection follows this order: master (code 0), when it is qualified; then slave (code 1); then stand-by (code 2); then none (code 3). A group whose alarm bit (`alarm_i[0]` master, `[1]` slave, `[2]` stand-by) was high at the sampling edge is never selected.
- R3: Master qualification works as follows. If master is not the current selection, it becomes eligible only after `alarm_i[0]` has been low on `HOLD_CYC` consecutive edges, so it is selected on the next edge. If master is the current selection, it stays eligible while its alarm is low.
- R4: In non-revertive operation (`revertive_i` = 0) without a forced choice, the current source is kept as long as its alarm stays low. When it fails, or when none is selected, the R2 order applies.
- R5: When `force_en_i` is high, the group named by `force_slave_i` (1 = slave, 0 = master) is selected if its alarm is low, with no qualification delay. If that group is in alarm, R2 or R4 applies.
- R6: When no group is usable, `sel_o` becomes 3. `mode_o` then becomes 2 (holdover) if the mode was locked or holdover, and stays free-run otherwise.
- R7: `mode_o` becomes 1 (locked) on an edge where a source is selected and `lock_i` is high. With a source selected and `lock_i` low, the mode is unchanged.
- R8: `switch_o` is high for exactly the cycles in which `sel_o` differs from its value in the previous cycle.
- R9: With `STANDBY_EN` = 0, the stand-by group is never selected, and the fallback after slave is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_i | input | 3 | Per-group failure flags: bit 0 master, bit 1 slave, bit 2 stand-by |
| force_en_i | input | 1 | Enables the forced master/slave choice |
| force_slave_i | input | 1 | Forced target: 1 slave, 0 master |
| revertive_i | input | 1 | 1 revertive, 0 non-revertive |
| lock_i | input | 1 | PLL lock indication |
| sel_o | output | 2 | Selected group: 0 master, 1 slave, 2 stand-by, 3 none |
| mode_o | output | 2 | 0 free-run, 1 locked, 2 holdover |
| switch_o | output | 1 | One-cycle flag on each change of selection |

## Verification
The hardest state to reach is the return to master in revertive operation. It needs a master failure, a fallback to a lower tier, and then an alarm that stays clear for exactly `HOLD_CYC` edges, one edge short of that, or broken by a single-cycle glitch. Random alarm toggling rarely produces such a run. A directed sequence therefore builds the situation and counts edges to the switch. Long random phases with sparse alarm toggles and slowly changing force and policy inputs cover the interaction of force, non-revertive hold and holdover entry. A second instance without the stand-by tier runs on the same stimulus.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
   typedef enum logic [1:0] {
      SRC_MASTER  = 2'd0,
      SRC_SLAVE   = 2'd1,
      SRC_STANDBY = 2'd2,
      SRC_NONE    = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      MD_FREE   = 2'd0,
      MD_LOCKED = 2'd1,
      MD_HOLD   = 2'd2
   } mode_e;

   localparam int unsigned NUM_GROUPS = 3;
endpackage

// File: rtl/rsel_qualify.sv
module rsel_qualify #(
   parameter int unsigned HOLD_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alarm_i,
   output logic qual_o
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

   logic [CW-1:0] clear_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              clear_cnt <= '0;
      else if (alarm_i)        clear_cnt <= '0;
      else if (clear_cnt < LIMIT) clear_cnt <= clear_cnt + 1'b1;
   end

   assign qual_o = (clear_cnt >= LIMIT);

   // R3: the counter never runs past its ceiling
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      clear_cnt <= LIMIT);
   // R3: a master alarm always withdraws qualification on the next edge
   a_r3_alarm_drops: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_i |=> !qual_o);
endmodule

// File: rtl/rsel_pick.sv
module rsel_pick
   import rsel_pkg::*;
#(
   parameter bit STANDBY_EN = 1'b1
) (
   input  logic [NUM_GROUPS-1:0] alarm_i,
   input  logic                  force_en_i,
   input  logic                  force_slave_i,
   input  logic                  revertive_i,
   input  logic                  m_qual_i,
   input  src_e                  cur_i,
   output src_e                  nxt_o
);
   logic [NUM_GROUPS-1:0] usable;
   logic                  m_ok;
   logic                  cur_ok;

   assign usable[0] = ~alarm_i[0];
   assign usable[1] = ~alarm_i[1];

   generate
      if (STANDBY_EN) begin : g_sb
         assign usable[2] = ~alarm_i[2];
      end else begin : g_nosb
         assign usable[2] = 1'b0;
      end
   endgenerate

   assign m_ok = usable[0] && (m_qual_i || cur_i == SRC_MASTER);

   always_comb begin
      case (cur_i)
         SRC_MASTER:  cur_ok = usable[0];
         SRC_SLAVE:   cur_ok = usable[1];
         SRC_STANDBY: cur_ok = usable[2];
         default:     cur_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (force_en_i && force_slave_i && usable[1])        nxt_o = SRC_SLAVE;
      else if (force_en_i && !force_slave_i && usable[0])  nxt_o = SRC_MASTER;
      else if (!revertive_i && cur_ok)                     nxt_o = cur_i;
      else if (m_ok)                                       nxt_o = SRC_MASTER;
      else if (usable[1])                                  nxt_o = SRC_SLAVE;
      else if (usable[2])                                  nxt_o = SRC_STANDBY;
      else                                                 nxt_o = SRC_NONE;
   end
endmodule

// File: rtl/rsel_mode.sv
module rsel_mode
   import rsel_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  src_e  nxt_i,
   input  src_e  cur_i,
   input  logic  lock_i,
   output mode_e mode_o,
   output logic  switch_o
);
   mode_e mode_q;
   logic  sw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MD_FREE;
         sw_q   <= 1'b0;
      end else begin
         sw_q <= (nxt_i != cur_i);
         if (nxt_i != SRC_NONE && lock_i)  mode_q <= MD_LOCKED;
         else if (nxt_i == SRC_NONE)       mode_q <= (mode_q == MD_FREE) ? MD_FREE : MD_HOLD;
      end
   end

   assign mode_o   = mode_q;
   assign switch_o = sw_q;

   // R6: holdover is only reachable from a locked history, never straight from free-run
   a_r6_no_free_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_HOLD) |-> ($past(mode_q) != MD_FREE));
   // R7: the mode never returns to free-run once it has left it
   a_r7_no_return_free: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_q) != MD_FREE) |-> (mode_q != MD_FREE));
endmodule

// File: rtl/refsel_top.sv
module refsel_top
   import rsel_pkg::*;
#(
   parameter int unsigned HOLD_CYC   = 16,
   parameter bit          STANDBY_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] alarm_i,
   input  logic       force_en_i,
   input  logic       force_slave_i,
   input  logic       revertive_i,
   input  logic       lock_i,
   output logic [1:0] sel_o,
   output logic [1:0] mode_o,
   output logic       switch_o
);
   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("refsel_top: HOLD_CYC must be at least 1");
      end
   endgenerate

   src_e  sel_q;
   src_e  sel_nxt;
   mode_e mode_w;
   logic  m_qual;

   rsel_qualify #(.HOLD_CYC(HOLD_CYC)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .alarm_i (alarm_i[0]),
      .qual_o  (m_qual)
   );

   rsel_pick #(.STANDBY_EN(STANDBY_EN)) u_pick (
      .alarm_i       (alarm_i),
      .force_en_i    (force_en_i),
      .force_slave_i (force_slave_i),
      .revertive_i   (revertive_i),
      .m_qual_i      (m_qual),
      .cur_i         (sel_q),
      .nxt_o         (sel_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= SRC_NONE;
      else        sel_q <= sel_nxt;
   end

   rsel_mode u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .nxt_i    (sel_nxt),
      .cur_i    (sel_q),
      .lock_i   (lock_i),
      .mode_o   (mode_w),
      .switch_o (switch_o)
   );

   assign sel_o  = sel_q;
   assign mode_o = mode_w;

   // R2: the selected group was not in alarm at the sampling edge
   a_r2_sel_healthy: assert property (@(posedge clk) disable iff (!rst_n)
      !((sel_q == SRC_MASTER  && $past(alarm_i[0])) ||
        (sel_q == SRC_SLAVE   && $past(alarm_i[1])) ||
        (sel_q == SRC_STANDBY && $past(alarm_i[2]))));
   // R3: an unforced move onto master needs a qualified master
   a_r3_master_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == SRC_MASTER && $past(sel_q) != SRC_MASTER && !$past(force_en_i))
         |-> $past(m_qual));
   // R4: non-revertive with a healthy current source holds it
   a_r4_nonrev_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!revertive_i && !force_en_i && sel_q == SRC_MASTER && !alarm_i[0]) |=> (sel_q == SRC_MASTER));
   a_r4_nonrev_hold_sl: assert property (@(posedge clk) disable iff (!rst_n)
      (!revertive_i && !force_en_i && sel_q == SRC_SLAVE && !alarm_i[1]) |=> (sel_q == SRC_SLAVE));
   // R5: a forced, healthy slave is taken on the next edge
   a_r5_force_slave: assert property (@(posedge clk) disable iff (!rst_n)
      (force_en_i && force_slave_i && !alarm_i[1]) |=> (sel_q == SRC_SLAVE));
   // R7: locked implies a source is selected
   a_r7_locked_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w == MD_LOCKED) |-> (sel_q != SRC_NONE));
   // R8: the flag and a change of selection coincide
   a_r8_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      switch_o |-> (sel_q != $past(sel_q)));
   a_r8_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q != $past(sel_q)) |-> switch_o);

   generate
      if (!STANDBY_EN) begin : g_chk_nosb
         // R9: no stand-by tier means code 2 never appears
         a_r9_no_standby: assert property (@(posedge clk) disable iff (!rst_n)
            sel_q != SRC_STANDBY);
      end
   endgenerate
endmodule

// File: tb/sim_refsel_top.sv
module sim_refsel_top;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] alarm = 3'b000;
   logic       fen = 1'b0, fsl = 1'b0, rev = 1'b1, lck = 1'b0;
   logic [1:0] sel0, mode0, sel1, mode1;
   logic       sw0, sw1;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   // model state for u0
   int m_sel = 3, m_mode = 0, m_sw = 0, m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refsel_top #(.HOLD_CYC(HOLD), .STANDBY_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .alarm_i(alarm), .force_en_i(fen),
      .force_slave_i(fsl), .revertive_i(rev), .lock_i(lck),
      .sel_o(sel0), .mode_o(mode0), .switch_o(sw0));

   refsel_top #(.HOLD_CYC(HOLD), .STANDBY_EN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .alarm_i(alarm), .force_en_i(fen),
      .force_slave_i(fsl), .revertive_i(rev), .lock_i(lck),
      .sel_o(sel1), .mode_o(mode1), .switch_o(sw1));

   function automatic int pick_f(input logic [2:0] al, input logic fe, input logic fs,
                                 input logic rv, input int cur, input bit qual);
      bit ok0 = !al[0], ok1 = !al[1], ok2 = !al[2];
      bit cur_ok = (cur == 0 && ok0) || (cur == 1 && ok1) || (cur == 2 && ok2);
      if (fe && fs && ok1) return 1;
      if (fe && !fs && ok0) return 0;
      if (!rv && cur_ok) return cur;
      if (ok0 && (qual || cur == 0)) return 0;
      if (ok1) return 1;
      if (ok2) return 2;
      return 3;
   endfunction

   function automatic int mode_f(input int nxt, input int md, input logic lk);
      if (nxt != 3 && lk) return 1;
      if (nxt == 3) return (md == 0) ? 0 : 2;
      return md;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // drive inputs at a falling edge, advance the model, compare at next falling edge
   task automatic step(input logic [2:0] al, input logic fe, input logic fs,
                       input logic rv, input logic lk);
      int nxt;
      alarm = al; fen = fe; fsl = fs; rev = rv; lck = lk;
      nxt = pick_f(al, fe, fs, rv, m_sel, m_cnt >= HOLD);
      m_sw   = (nxt != m_sel);
      m_mode = mode_f(nxt, m_mode, lk);
      m_sel  = nxt;
      m_cnt  = al[0] ? 0 : ((m_cnt < HOLD) ? m_cnt + 1 : m_cnt);
      @(negedge clk);
      check(fe ? "R5 sel" : (!rv ? "R4 sel" : "R2 sel"), int'(sel0), m_sel);
      check((m_sel == 3) ? "R6 mode" : "R7 mode", int'(mode0), m_mode);
      check("R8 switch", int'(sw0), m_sw);
      if (sel1 == 2'd2) check("R9 no standby", int'(sel1), 3);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'h5EED_0123;
      logic [2:0] al;
      logic fe, fs, rv, lk;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 sel", int'(sel0), 3);
      check("R1 mode", int'(mode0), 0);
      check("R1 switch", int'(sw0), 0);
      rst_n = 1'b1;

      // R3: master qualification after reset (alarm clear from the start)
      for (int i = 0; i < HOLD; i++) begin
         step(3'b000, 0, 0, 1, 1);
         check("R3 slave while qualifying", int'(sel0), 1);
      end
      step(3'b000, 0, 0, 1, 1);
      check("R3 master after hold", int'(sel0), 0);
      check("R8 pulse on revert", int'(sw0), 1);
      check("R7 locked", int'(mode0), 1);

      // R3: glitch restarts qualification
      step(3'b001, 0, 0, 1, 1);
      check("R2 fallback to slave", int'(sel0), 1);
      for (int i = 0; i < HOLD - 2; i++) step(3'b000, 0, 0, 1, 1);
      step(3'b001, 0, 0, 1, 1);
      for (int i = 0; i < HOLD; i++) step(3'b000, 0, 0, 1, 1);
      check("R3 still slave after glitch", int'(sel0), 1);
      step(3'b000, 0, 0, 1, 1);
      check("R3 master after clean hold", int'(sel0), 0);

      // R9 / R2: master and slave down -> standby on u0, none on u1
      step(3'b011, 0, 0, 1, 1);
      check("R2 standby", int'(sel0), 2);
      check("R9 none without standby", int'(sel1), 3);
      check("R6 holdover on u1", int'(mode1), 2);

      // R6: all down -> holdover
      step(3'b111, 0, 0, 1, 0);
      check("R6 none", int'(sel0), 3);
      check("R6 holdover", int'(mode0), 2);

      // R4: non-revertive keeps slave after master recovers
      step(3'b101, 0, 0, 0, 0);
      check("R7 mode kept without lock", int'(mode0), 2);
      for (int i = 0; i < HOLD + 3; i++) step(3'b100, 0, 0, 0, 1);
      check("R4 stays on slave", int'(sel0), 1);

      // R5: forced master honoured at once; forced slave in alarm falls back
      step(3'b100, 1, 0, 0, 1);
      check("R5 forced master", int'(sel0), 0);
      step(3'b110, 1, 1, 1, 1);
      check("R5 forced slave in alarm", int'(sel0), 0);

      // random phase
      al = 3'b000; fe = 0; fs = 0; rv = 1; lk = 1;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 5) == 0) al[$urandom_range(0, 2)] ^= 1'b1;
         if ($urandom_range(0, 60) == 0) fe = ~fe;
         if ($urandom_range(0, 30) == 0) fs = ~fs;
         if ($urandom_range(0, 80) == 0) rv = ~rv;
         if ($urandom_range(0, 10) == 0) lk = ~lk;
         step(al, fe, fs, rv, lk);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule